// File: doc/BRIEF.md
# Qualified Cache Event Counter

This block counts cache events for a performance monitor. Every cycle it receives up to `NUM_LANES` event pulses. Each pulse carries the following:

- an 8-bit event code;
- the coherence state of the cache line;
- a flag that marks requests issued by a hardware prefetcher;
- a flag set when the request comes from this core;
- a flag set when the request comes from this agent.

A 32-bit control word selects one event code, sets up the qualification filters and enables counting. Each cycle, the number of pulses that pass the filters is added to a 40-bit counter. Software can read the counter and overwrite it.

An internal capability table decides which filters apply to each event code. State-qualified events count only the states admitted by a four-bit state mask, so an empty mask stops them from counting. Prefetch-qualified events use a two-bit prefetch filter. On agent-qualified events, bit 13 is an agent filter instead, which is why prefetch and agent qualification can never apply together. Core qualification can be combined with either of them. Events with no capabilities ignore every qualification field. A control write takes effect on the cycle after the write.

Top module: `qual_event_counter`

## Requirements
- R1: After reset, `cnt_rdata`, `cfg_rdata` and `cfg_err` are all zero.
- R2: A lane counts when it is valid, its code equals control bits 7:0 and it passes its filters. The counter then rises by the number of counting lanes in that cycle (0 to `NUM_LANES`), and the new value is visible after the next clock edge.
- R3: While enable (control bit 22) is 0, the counter does not change, unless software writes the counter.
- R4: For state-qualified events, the state mask is control bits 11:8. Bit 11 admits Modified (state code 3), bit 10 Exclusive (code 2), bit 9 Shared (code 1) and bit 8 Invalid (code 0). A lane counts only if the bit for its state is set.
- R5: For a state-qualified event with a state mask of 0000, nothing is counted.
- R6: For prefetch-qualified events, control bits 13:12 act as follows: 11 counts every request, 01 counts only hardware-prefetch requests, and 00 counts only requests that are not hardware prefetches.
- R7: For a prefetch-qualified event, the value 10 in bits 13:12 counts nothing. A control write that stores it sets `cfg_err`, and `cfg_err` then stays at 1 until reset.
- R8: For agent-qualified events, bit 13 set counts all agents, and bit 13 clear counts only lanes with `evt_self_agent` set. Bit 12 and the prefetch flag have no effect on these events.
- R9: For core-qualified events, bit 14 set counts all cores, and bit 14 clear counts only lanes with `evt_self_core` set.
- R10: The capability table is as follows. Codes 0x20–0x2F support core, prefetch and state qualification. Codes 0x30–0x3F support core, agent and state qualification. Codes 0x40–0x4F support core and prefetch qualification. All other codes support none, so bits 14:8 have no effect on them and never set `cfg_err`.
- R11: `cnt_we` loads `cnt_wdata` into the counter at the next edge. This load takes priority over any increment in the same cycle.
- R12: The counter wraps modulo 2^40.
- R13: A control write is stored at the next edge. Events in the write cycle are qualified against the old control value, and events from the following cycle on are qualified against the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Current control word |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | 40 | Counter load value |
| cnt_rdata | output | 40 | Current counter value |
| evt_valid | input | NUM_LANES | Per-lane event pulse |
| evt_code | input | 8*NUM_LANES | Per-lane event code, lane i at bits 8i+7:8i |
| evt_state | input | 2*NUM_LANES | Per-lane coherence state code (3=M, 2=E, 1=S, 0=I) |
| evt_hwpf | input | NUM_LANES | Per-lane hardware-prefetch flag |
| evt_self_core | input | NUM_LANES | Per-lane flag: request from this core |
| evt_self_agent | input | NUM_LANES | Per-lane flag: request from this agent |
| cfg_err | output | 1 | Sticky flag: reserved prefetch encoding was configured |

## Verification
The hardest situations to reach are the ones where two things happen in the same cycle:

- a counter load together with counting lanes;
- a control write together with events that the new control value would filter differently.

The bench drives both in one cycle and checks that the load wins, and that the old filter still decides. Wrap-around needs a counter near 2^40, so the bench preloads the counter two below the limit instead of counting up to it.

// File: rtl/qec_pkg.sv
package qec_pkg;

  typedef struct packed {
    logic core;
    logic agent;
    logic pf;
    logic state;
  } qual_cap_t;

  typedef struct packed {
    logic       en;
    logic       core_all;
    logic [1:0] pf_qual;
    logic [3:0] st_mask;
    logic [7:0] sel;
  } cfg_view_t;

  // Per-event capability table, derived from the upper code nibble.
  function automatic qual_cap_t cap_lookup(input logic [7:0] code);
    qual_cap_t c;
    c = '{core: 1'b0, agent: 1'b0, pf: 1'b0, state: 1'b0};
    case (code[7:4])
      4'h2: c = '{core: 1'b1, agent: 1'b0, pf: 1'b1, state: 1'b1};
      4'h3: c = '{core: 1'b1, agent: 1'b1, pf: 1'b0, state: 1'b1};
      4'h4: c = '{core: 1'b1, agent: 1'b0, pf: 1'b1, state: 1'b0};
      default: ;
    endcase
    return c;
  endfunction

  // Prefetch filter; the reserved encoding admits nothing.
  function automatic logic pf_pass(input logic [1:0] q, input logic hwpf);
    case (q)
      2'b11:   return 1'b1;
      2'b01:   return hwpf;
      2'b00:   return !hwpf;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic state_pass(input logic [3:0] mask, input logic [1:0] st);
    return mask[st];
  endfunction

endpackage

// File: rtl/qec_cfg_reg.sv
module qec_cfg_reg
  import qec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_q,
  output logic        cfg_err
);

  qual_cap_t wr_cap;
  logic      wr_reserved;

  assign wr_cap      = cap_lookup(cfg_wdata[7:0]);
  assign wr_reserved = wr_cap.pf && (cfg_wdata[13:12] == 2'b10);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      cfg_err <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      if (cfg_we && wr_reserved) cfg_err <= 1'b1;
    end
  end

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cfg_err));

  assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wr_reserved) |=> cfg_err);

  assert_cfg_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q == $past(cfg_wdata)));

endmodule

// File: rtl/qec_lane_filter.sv
module qec_lane_filter
  import qec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cfg_view_t  cfg,
  input  logic       valid,
  input  logic [7:0] code,
  input  logic [1:0] state,
  input  logic       hwpf,
  input  logic       self_core,
  input  logic       self_agent,
  output logic       hit
);

  qual_cap_t cap;
  logic      sel_match;
  logic      state_ok;
  logic      pf_ok;
  logic      agent_ok;
  logic      core_ok;

  assign cap       = cap_lookup(code);
  assign sel_match = cfg.en && valid && (code == cfg.sel);
  assign state_ok  = !cap.state || state_pass(cfg.st_mask, state);
  assign pf_ok     = !cap.pf    || pf_pass(cfg.pf_qual, hwpf);
  // Agent events reuse bit 13 as the all-agents select.
  assign agent_ok  = !cap.agent || cfg.pf_qual[1] || self_agent;
  assign core_ok   = !cap.core  || cfg.core_all   || self_core;
  assign hit       = sel_match && state_ok && pf_ok && agent_ok && core_ok;

  assert_empty_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap.state && cfg.st_mask == 4'b0000) |-> !hit);

  assert_pf_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cap.pf && cfg.pf_qual == 2'b01) |-> hwpf);

  assert_pf_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cap.pf && cfg.pf_qual == 2'b00) |-> !hwpf);

  assert_reserved_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap.pf && cfg.pf_qual == 2'b10) |-> !hit);

  assert_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> !hit);

endmodule

// File: rtl/qec_accum.sv
module qec_accum #(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LANES-1:0] hits,
  input  logic                 cnt_we,
  input  logic [CNT_W-1:0]     cnt_wdata,
  output logic [CNT_W-1:0]     cnt_q
);

  localparam int PC_W = $clog2(NUM_LANES + 1);

  function automatic logic [PC_W-1:0] ones(input logic [NUM_LANES-1:0] v);
    logic [PC_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_LANES; i++) r = r + PC_W'(v[i]);
    return r;
  endfunction

  logic [PC_W-1:0] step;
  assign step = ones(hits);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_wdata;
    else             cnt_q <= cnt_q + CNT_W'(step);
  end

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(cnt_wdata)));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && hits == '0) |=> $stable(cnt_q));

  assert_step_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(NUM_LANES)));

endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
  import qec_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  input  logic                   cnt_we,
  input  logic [CNT_W-1:0]       cnt_wdata,
  output logic [CNT_W-1:0]       cnt_rdata,
  input  logic [NUM_LANES-1:0]   evt_valid,
  input  logic [8*NUM_LANES-1:0] evt_code,
  input  logic [2*NUM_LANES-1:0] evt_state,
  input  logic [NUM_LANES-1:0]   evt_hwpf,
  input  logic [NUM_LANES-1:0]   evt_self_core,
  input  logic [NUM_LANES-1:0]   evt_self_agent,
  output logic                   cfg_err
);

  logic [31:0]          cfg_q;
  cfg_view_t            cfgv;
  logic [NUM_LANES-1:0] lane_hit;

  qec_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q),
    .cfg_err   (cfg_err)
  );

  assign cfgv = '{en:       cfg_q[22],
                  core_all: cfg_q[14],
                  pf_qual:  cfg_q[13:12],
                  st_mask:  cfg_q[11:8],
                  sel:      cfg_q[7:0]};

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    qec_lane_filter u_filt (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg        (cfgv),
      .valid      (evt_valid[g]),
      .code       (evt_code[8*g +: 8]),
      .state      (evt_state[2*g +: 2]),
      .hwpf       (evt_hwpf[g]),
      .self_core  (evt_self_core[g]),
      .self_agent (evt_self_agent[g]),
      .hit        (lane_hit[g])
    );
  end

  qec_accum #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .hits      (lane_hit),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .cnt_q     (cnt_rdata)
  );

  assign cfg_rdata = cfg_q;

endmodule

// File: tb/qual_event_counter_tb.sv
module qual_event_counter_tb;

  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [31:0]   cfg_wdata;
  logic [31:0]   cfg_rdata;
  logic          cnt_we;
  logic [39:0]   cnt_wdata;
  logic [39:0]   cnt_rdata;
  logic [N-1:0]  evt_valid;
  logic [8*N-1:0] evt_code;
  logic [2*N-1:0] evt_state;
  logic [N-1:0]  evt_hwpf;
  logic [N-1:0]  evt_self_core;
  logic [N-1:0]  evt_self_agent;
  logic          cfg_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] cfg_model;
  logic [39:0] exp_cnt;

  always #2 clk = ~clk;

  qual_event_counter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cnt_rdata(cnt_rdata), .evt_valid(evt_valid), .evt_code(evt_code),
    .evt_state(evt_state), .evt_hwpf(evt_hwpf), .evt_self_core(evt_self_core),
    .evt_self_agent(evt_self_agent), .cfg_err(cfg_err)
  );

  function automatic logic [31:0] cw(bit en, bit core_all, logic [1:0] pf,
                                     logic [3:0] mask, logic [7:0] sel);
    return {9'b0, en, 7'b0, core_all, pf, mask, sel};
  endfunction

  // Independent model of whether one lane counts.
  function automatic bit m_hit(logic [31:0] c, logic [7:0] code, logic [1:0] st,
                               bit pf, bit sc, bit sa);
    bit k_core, k_agent, k_pf, k_st;
    k_core  = (code >= 8'h20 && code <= 8'h4F);
    k_agent = (code >= 8'h30 && code <= 8'h3F);
    k_pf    = (code >= 8'h20 && code <= 8'h2F) || (code >= 8'h40 && code <= 8'h4F);
    k_st    = (code >= 8'h20 && code <= 8'h3F);
    if (c[22] == 1'b0) return 0;
    if (code != c[7:0]) return 0;
    if (k_st) begin
      if (st == 2'd3 && !c[11]) return 0;
      if (st == 2'd2 && !c[10]) return 0;
      if (st == 2'd1 && !c[9])  return 0;
      if (st == 2'd0 && !c[8])  return 0;
    end
    if (k_pf) begin
      if (c[13:12] == 2'b10) return 0;
      if (c[13:12] == 2'b01 && !pf) return 0;
      if (c[13:12] == 2'b00 && pf) return 0;
    end
    if (k_agent && !c[13] && !sa) return 0;
    if (k_core && !c[14] && !sc) return 0;
    return 1;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic clear_lanes();
    evt_valid = '0; evt_code = '0; evt_state = '0;
    evt_hwpf = '0; evt_self_core = '0; evt_self_agent = '0;
  endtask

  task automatic set_lane(int i, logic [7:0] code, logic [1:0] st, bit pf, bit sc, bit sa);
    evt_valid[i] = 1'b1;
    evt_code[8*i +: 8] = code;
    evt_state[2*i +: 2] = st;
    evt_hwpf[i] = pf;
    evt_self_core[i] = sc;
    evt_self_agent[i] = sa;
  endtask

  function automatic int model_delta();
    int d = 0;
    for (int i = 0; i < N; i++)
      if (evt_valid[i] && m_hit(cfg_model, evt_code[8*i +: 8], evt_state[2*i +: 2],
                                evt_hwpf[i], evt_self_core[i], evt_self_agent[i]))
        d++;
    return d;
  endfunction

  // Lanes already set; run one cycle and compare the counter.
  task automatic tick_check(string tag);
    int d;
    d = model_delta();
    @(negedge clk);
    clear_lanes();
    exp_cnt = exp_cnt + 40'(d);
    check(cnt_rdata == exp_cnt, tag, 64'(cnt_rdata), 64'(exp_cnt));
  endtask

  task automatic write_cfg(logic [31:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_model = w;
  endtask

  task automatic write_cnt(logic [39:0] v);
    cnt_we = 1'b1; cnt_wdata = v;
    @(negedge clk);
    cnt_we = 1'b0;
    exp_cnt = v;
    check(cnt_rdata == v, "R11 load", 64'(cnt_rdata), 64'(v));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 0; cnt_we = 0; cfg_wdata = '0; cnt_wdata = '0;
    clear_lanes();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cfg_model = '0; exp_cnt = '0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check(cnt_rdata == 0, "R1 cnt", 64'(cnt_rdata), 0);
    check(cfg_rdata == 0, "R1 cfg", 64'(cfg_rdata), 0);
    check(cfg_err == 0, "R1 err", 64'(cfg_err), 0);
  endtask

  task automatic t_basic();
    write_cfg(cw(1, 0, 2'b00, 4'h0, 8'h05));
    set_lane(2, 8'h05, 0, 0, 0, 0);
    tick_check("R2 single lane");
    set_lane(0, 8'h05, 0, 0, 0, 0); set_lane(1, 8'h05, 1, 1, 0, 0);
    set_lane(2, 8'h06, 0, 0, 0, 0); set_lane(3, 8'h05, 3, 0, 1, 1);
    tick_check("R2 three of four");
    for (int i = 0; i < N; i++) set_lane(i, 8'h05, 2'(i), 0, 0, 0);
    tick_check("R2 all lanes");
    for (int i = 0; i < N; i++) set_lane(i, 8'h15, 0, 0, 0, 0);
    tick_check("R2 no match");
  endtask

  task automatic t_enable();
    write_cfg(cw(0, 1, 2'b11, 4'hF, 8'h05));
    for (int i = 0; i < N; i++) set_lane(i, 8'h05, 0, 0, 1, 1);
    tick_check("R3 disabled");
  endtask

  task automatic t_state();
    write_cfg(cw(1, 1, 2'b11, 4'b1000, 8'h21));
    set_lane(0, 8'h21, 3, 0, 1, 1); set_lane(1, 8'h21, 2, 0, 1, 1);
    set_lane(2, 8'h21, 1, 0, 1, 1); set_lane(3, 8'h21, 0, 0, 1, 1);
    tick_check("R4 modified only");
    write_cfg(cw(1, 1, 2'b11, 4'b0101, 8'h21));
    set_lane(0, 8'h21, 3, 0, 1, 1); set_lane(1, 8'h21, 2, 0, 1, 1);
    set_lane(2, 8'h21, 1, 0, 1, 1); set_lane(3, 8'h21, 0, 0, 1, 1);
    tick_check("R4 exclusive and invalid");
  endtask

  task automatic t_empty();
    write_cfg(cw(1, 1, 2'b11, 4'b0000, 8'h33));
    for (int i = 0; i < N; i++) set_lane(i, 8'h33, 2'(i), 0, 1, 1);
    tick_check("R5 empty mask");
  endtask

  task automatic t_prefetch();
    write_cfg(cw(1, 1, 2'b01, 4'hF, 8'h22));
    set_lane(0, 8'h22, 3, 1, 1, 0); set_lane(1, 8'h22, 2, 1, 1, 0);
    set_lane(2, 8'h22, 1, 0, 1, 0); set_lane(3, 8'h22, 0, 0, 1, 0);
    tick_check("R6 prefetch only");
    write_cfg(cw(1, 1, 2'b00, 4'hF, 8'h22));
    set_lane(0, 8'h22, 3, 1, 1, 0); set_lane(1, 8'h22, 2, 0, 1, 0);
    set_lane(2, 8'h22, 1, 0, 1, 0); set_lane(3, 8'h22, 0, 0, 1, 0);
    tick_check("R6 exclude prefetch");
    write_cfg(cw(1, 1, 2'b11, 4'h0, 8'h41));
    set_lane(0, 8'h41, 0, 1, 1, 0); set_lane(1, 8'h41, 0, 0, 1, 0);
    tick_check("R6 all requests, no state check");
  endtask

  task automatic t_reserved();
    check(cfg_err == 0, "R7 err before", 64'(cfg_err), 0);
    write_cfg(cw(1, 1, 2'b10, 4'hF, 8'h22));
    check(cfg_err == 1, "R7 err set", 64'(cfg_err), 1);
    for (int i = 0; i < N; i++) set_lane(i, 8'h22, 3, 2'(i) == 1, 1, 1);
    tick_check("R7 reserved counts nothing");
    write_cfg(cw(1, 1, 2'b11, 4'hF, 8'h22));
    check(cfg_err == 1, "R7 err sticky", 64'(cfg_err), 1);
  endtask

  task automatic t_agent();
    write_cfg(cw(1, 1, 2'b01, 4'hF, 8'h31));
    set_lane(0, 8'h31, 3, 0, 1, 1); set_lane(1, 8'h31, 3, 0, 1, 0);
    set_lane(2, 8'h31, 3, 0, 1, 0); set_lane(3, 8'h31, 3, 0, 1, 1);
    tick_check("R8 own agent only");
    write_cfg(cw(1, 1, 2'b10, 4'hF, 8'h31));
    check(cfg_err == 0, "R8 no err on agent event", 64'(cfg_err), 0);
    set_lane(0, 8'h31, 3, 1, 1, 1); set_lane(1, 8'h31, 3, 0, 1, 0);
    set_lane(2, 8'h31, 3, 1, 1, 0); set_lane(3, 8'h31, 3, 0, 1, 1);
    tick_check("R8 all agents");
  endtask

  task automatic t_core();
    write_cfg(cw(1, 0, 2'b11, 4'hF, 8'h23));
    set_lane(0, 8'h23, 3, 0, 1, 0); set_lane(1, 8'h23, 3, 0, 0, 0);
    set_lane(2, 8'h23, 3, 0, 1, 0); set_lane(3, 8'h23, 3, 0, 0, 0);
    tick_check("R9 own core only");
  endtask

  task automatic t_noqual();
    write_cfg(cw(1, 0, 2'b10, 4'h0, 8'h07));
    check(cfg_err == 0, "R10 no err", 64'(cfg_err), 0);
    for (int i = 0; i < N; i++) set_lane(i, 8'h07, 2'(i), 1, 0, 0);
    tick_check("R10 fields ignored");
  endtask

  task automatic t_write();
    write_cnt(40'h123);
    write_cfg(cw(1, 0, 2'b00, 4'h0, 8'h05));
    for (int i = 0; i < N; i++) set_lane(i, 8'h05, 0, 0, 0, 0);
    cnt_we = 1'b1; cnt_wdata = 40'hAB_0000_0001;
    @(negedge clk);
    cnt_we = 1'b0; clear_lanes();
    exp_cnt = 40'hAB_0000_0001;
    check(cnt_rdata == exp_cnt, "R11 load beats increment", 64'(cnt_rdata), 64'(exp_cnt));
  endtask

  task automatic t_wrap();
    write_cnt(40'hFF_FFFF_FFFE);
    for (int i = 0; i < N; i++) set_lane(i, 8'h05, 0, 0, 0, 0);
    tick_check("R12 wrap");
    check(cnt_rdata == 40'd2, "R12 wrapped value", 64'(cnt_rdata), 2);
  endtask

  task automatic t_cfg_timing();
    logic [31:0] nw;
    write_cfg(cw(1, 1, 2'b11, 4'hF, 8'h21));
    nw = cw(1, 1, 2'b11, 4'h0, 8'h21);
    for (int i = 0; i < N; i++) set_lane(i, 8'h21, 2'(i), 0, 1, 1);
    cfg_we = 1'b1; cfg_wdata = nw;
    tick_check("R13 old config in write cycle");
    cfg_we = 1'b0; cfg_model = nw;
    check(cfg_rdata == nw, "R13 stored", 64'(cfg_rdata), 64'(nw));
    for (int i = 0; i < N; i++) set_lane(i, 8'h21, 2'(i), 0, 1, 1);
    tick_check("R13 new config next cycle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_enable();
    t_state();
    t_empty();
    t_prefetch();
    t_reserved();
    do_reset();
    t_agent();
    t_core();
    t_noqual();
    t_write();
    t_wrap();
    t_cfg_timing();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule